// File: doc/BRIEF.md
# Port Pin Interrupt Controller

This block watches an 8-bit general-purpose port and merges chosen pin transitions into a single interrupt request. Software programs three per-pin masks and one status/control register through a small register port. The masks choose which pins take part, which edge each pin reacts to, and whether the pin's internal resistor is switched on. The status/control register holds the interrupt enable and the pending flag, plus a write-one acknowledge bit.

Each pin is brought into the clock domain by a two-stage synchroniser, and the block then compares it with its value one cycle earlier. A selected pin whose polarity bit is 0 reacts to a falling edge. A selected pin whose polarity bit is 1 reacts to a rising edge. The same polarity bit also chooses the resistor direction: 0 gives a pull-up and 1 gives a pull-down. A resistor is only switched on for a pin that is both selected and pull-enabled.

Enabling pins can raise a false pending flag. Software should therefore program the masks with the interrupt enable cleared, acknowledge any pending flag, and then set the enable.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `irq_req` is 0, and every `pull_up` and `pull_down` bit is 0.
- R2: Register addresses are: 1 = pin select, 2 = polarity, 3 = pull enable, each read and written as a full byte. Address 0 is status/control, where bit 0 is the acknowledge bit and always reads 0, bit 1 is the interrupt enable (read/write), bit 2 is the pending flag (read-only; writes to it have no effect), and bits 7..3 read 0.
- R3: A transition on a pin whose select bit is 0 never sets the pending flag.
- R4: On a selected pin, polarity 0 sets the flag on a falling edge only, and polarity 1 sets the flag on a rising edge only.
- R5: A pin change made between clock edges shows up in the flag on the third rising clock edge after the change, and not on the second.
- R6: `irq_req` is high exactly when the pending flag is set and the interrupt enable is 1. The flag stays pending while the enable is 0.
- R7: Writing address 0 with bit 0 set clears the pending flag. Writing address 0 with bit 0 clear leaves the flag unchanged.
- R8: If an active edge is detected in the same cycle as an acknowledge write, the flag stays set.
- R9: `pull_up[i]` is 1 when select, pull enable and not-polarity are all 1 for pin i. `pull_down[i]` is 1 when select, pull enable and polarity are all 1 for pin i. Otherwise both are 0, and the two are never both 1.
- R10: The pending flag is the OR over all pins: an active edge on any single selected pin sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 8 | Raw port pin levels |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| irq_req | output | 1 | Interrupt request |
| pull_up | output | 8 | Per-pin pull-up enable to the pad |
| pull_down | output | 8 | Per-pin pull-down enable to the pad |

## Verification
A stuck or wrongly cleared pending flag appears on `irq_req` and in bit 2 of address 0 on the next clock edge. A broken synchroniser or edge stage moves the flag's rise away from the third edge after a pin change, and the bench checks both that edge and the one before it. A wrong select, polarity or pull-enable state appears at once on the combinational pull outputs and in register reads, and it also shows as a missing or spurious flag on the third edge after a test pin change.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_SELECT = 2'd1,
    REG_POLAR  = 2'd2,
    REG_PULLEN = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_ACK_BIT  = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
  localparam int unsigned CTRL_FLAG_BIT = 2;

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= din;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pinirq_edge.sv
module pinirq_edge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] pol,
  output logic [W-1:0] hit,
  output logic         any_hit
);
  logic [W-1:0] prev_q;

  function automatic logic [W-1:0] edge_vec(input logic [W-1:0] cur,
                                            input logic [W-1:0] prv,
                                            input logic [W-1:0] p,
                                            input logic [W-1:0] s);
    logic [W-1:0] rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    return s & ((p & rise) | (~p & fall));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign hit     = edge_vec(level, prev_q, pol, sel);
  assign any_hit = |hit;
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
  import pinirq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         any_hit,
  output logic [W-1:0] sel_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] pen_q,
  output logic         ie_q,
  output logic         flag_q,
  output logic         ack_wr,
  output logic [W-1:0] rdata
);
  reg_addr_e    a;
  logic         flag_nxt;
  logic [W-1:0] ctrl_view;

  assign a      = reg_addr_e'(addr);
  assign ack_wr = we && (a == REG_CTRL) && wdata[CTRL_ACK_BIT];

  function automatic logic next_flag(input logic cur, input logic set,
                                     input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  assign flag_nxt = next_flag(flag_q, any_hit, ack_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      pol_q  <= '0;
      pen_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      if (we) begin
        unique case (a)
          REG_CTRL:   ie_q  <= wdata[CTRL_IE_BIT];
          REG_SELECT: sel_q <= wdata;
          REG_POLAR:  pol_q <= wdata;
          REG_PULLEN: pen_q <= wdata;
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_IE_BIT]   = ie_q;
    ctrl_view[CTRL_FLAG_BIT] = flag_q;
  end

  always_comb begin
    unique case (a)
      REG_CTRL:   rdata = ctrl_view;
      REG_SELECT: rdata = sel_q;
      REG_POLAR:  rdata = pol_q;
      REG_PULLEN: rdata = pen_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinirq_pull.sv
module pinirq_pull #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] pen,
  output logic [W-1:0] pu,
  output logic [W-1:0] pd
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic on;
    assign on    = sel[i] & pen[i];
    assign pu[i] = on & ~pol[i];
    assign pd[i] = on &  pol[i];
  end
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [1:0]   reg_addr,
  input  logic         reg_we,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq_req,
  output logic [W-1:0] pull_up,
  output logic [W-1:0] pull_down
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] edge_hit;
  logic         any_edge;
  logic [W-1:0] sel_q, pol_q, pen_q;
  logic         ie_q, flag_q, ack_wr;

  pinirq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
  );

  pinirq_edge #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(pin_sync), .sel(sel_q), .pol(pol_q),
    .hit(edge_hit), .any_hit(any_edge)
  );

  pinirq_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata), .any_hit(any_edge), .sel_q(sel_q), .pol_q(pol_q),
    .pen_q(pen_q), .ie_q(ie_q), .flag_q(flag_q), .ack_wr(ack_wr),
    .rdata(reg_rdata)
  );

  pinirq_pull #(.W(W)) u_pull (
    .sel(sel_q), .pol(pol_q), .pen(pen_q), .pu(pull_up), .pd(pull_down)
  );

  assign irq_req = flag_q & ie_q;
endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         any_edge,
  input logic         ack_wr,
  input logic         flag_q,
  input logic         ie_q,
  input logic [W-1:0] sel_q,
  input logic         irq_req,
  input logic [W-1:0] pull_up,
  input logic [W-1:0] pull_down
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_req && pull_up == '0 && pull_down == '0)); // R1

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !any_edge) |=> !flag_q); // R3

  AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ie_q && flag_q)); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !any_edge) |=> !flag_q); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack_wr) |=> flag_q); // R7

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any_edge |=> flag_q); // R8

  AST_PULL_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_up | pull_down) & ~sel_q) == '0); // R9

  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pull_up & pull_down) == 0); // R9
endmodule

bind pinirq_ctrl pinirq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .any_edge(any_edge), .ack_wr(ack_wr),
  .flag_q(flag_q), .ie_q(ie_q), .sel_q(sel_q), .irq_req(irq_req),
  .pull_up(pull_up), .pull_down(pull_down)
);

// File: tb/sim_pinirq_ctrl.sv
module sim_pinirq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [7:0] pull_up, pull_down;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         kind;   // 0 irq, 1 rdata, 2 pull_up, 3 pull_down
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  pinirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .pull_up(pull_up), .pull_down(pull_down)
  );

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = q.pop_front();
      case (it.kind)
        0:       got = {7'd0, irq_req};
        1:       got = reg_rdata;
        2:       got = pull_up;
        default: got = pull_down;
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind,
                 got, it.exp);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_item(input int kind, input logic [7:0] e,
                             input string req);
    item_t it;
    it.kind = kind; it.exp = e; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e,
                    input string req);
    reg_addr = a;
    expect_item(1, e, req);
    tick();
  endtask

  task automatic irq_is(input logic e, input string req);
    expect_item(0, {7'd0, e}, req);
    tick();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    expect_item(0, 8'h00, "R1 irq");
    expect_item(2, 8'h00, "R1 pull_up");
    expect_item(3, 8'h00, "R1 pull_down");
    tick();
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 select");
    rd(2'd2, 8'h00, "R1 polarity");
    rd(2'd3, 8'h00, "R1 pull enable");

    // R2 register map, pins static so no flag
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'hF0);
    rd(2'd1, 8'hA5, "R2 select");
    rd(2'd2, 8'h3C, "R2 polarity");
    rd(2'd3, 8'hF0, "R2 pull enable");
    wr(2'd0, 8'hFE);
    rd(2'd0, 8'h02, "R2 ctrl ack reads 0 flag read-only");

    // R9 pulls: A5&F0 = A0; up = A0&~3C = 80, down = A0&3C = 20
    expect_item(2, 8'h80, "R9 pull_up");
    expect_item(3, 8'h20, "R9 pull_down");
    tick();
    wr(2'd1, 8'h00);
    expect_item(2, 8'h00, "R9 pull_up unselected");
    expect_item(3, 8'h00, "R9 pull_down unselected");
    tick();
    wr(2'd0, 8'h00);

    // R3 unselected pins toggle, selected pin 0 stays
    wr(2'd1, 8'h01); wr(2'd2, 8'hFF); wr(2'd3, 8'h00);
    pin_in = 8'hFE; tick(4);
    pin_in = 8'h00; tick(4);
    rd(2'd0, 8'h00, "R3 unselected edges ignored");

    // R4 polarity 0: rising ignored, falling sets
    wr(2'd2, 8'h00);
    pin_in = 8'h01; tick(4);
    rd(2'd0, 8'h00, "R4 rising ignored at polarity 0");
    pin_in = 8'h00; tick(4);
    rd(2'd0, 8'h04, "R4 falling sets at polarity 0");
    wr(2'd0, 8'h01);
    rd(2'd0, 8'h00, "R7 ack clears");

    // R4 polarity 1: falling ignored, rising sets
    wr(2'd2, 8'h01);
    pin_in = 8'h01; tick(4);
    rd(2'd0, 8'h04, "R4 rising sets at polarity 1");
    wr(2'd0, 8'h01);
    pin_in = 8'h00; tick(4);
    rd(2'd0, 8'h00, "R4 falling ignored at polarity 1");

    // R5 latency with interrupt enabled
    wr(2'd0, 8'h02);
    pin_in = 8'h01;
    irq_is(1'b0, "R5 before first edge");
    irq_is(1'b0, "R5 after first edge");
    irq_is(1'b0, "R5 after second edge");
    irq_is(1'b1, "R5 after third edge");

    // R6 gating, R7 writing 0 to ack keeps flag
    wr(2'd0, 8'h00);
    irq_is(1'b0, "R6 irq masked");
    rd(2'd0, 8'h04, "R7 flag kept with ack 0");
    wr(2'd0, 8'h02);
    irq_is(1'b1, "R6 irq unmasked");
    wr(2'd0, 8'h03);
    irq_is(1'b0, "R7 ack clears irq");

    // R8 edge coincident with ack
    pin_in = 8'h00; tick(4);
    pin_in = 8'h01;
    tick(2);
    reg_addr = 2'd0; reg_wdata = 8'h03; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
    irq_is(1'b1, "R8 edge wins over ack");
    wr(2'd0, 8'h03);
    irq_is(1'b0, "R8 later ack clears");

    // R10 any single selected pin sets the flag
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    pin_in = 8'h00; tick(4);
    wr(2'd0, 8'h03);
    irq_is(1'b0, "R10 quiet before");
    pin_in = 8'h80; tick(3);
    irq_is(1'b1, "R10 pin 7 alone");
    wr(2'd0, 8'h03);
    pin_in = 8'h88; tick(3);
    irq_is(1'b1, "R10 pin 3 alone");

    tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule